// File: doc/BRIEF.md
# System Protection Unit: Key-Serviced Watchdog and Bus Cycle Monitor

This block guards a small microcontroller bus against two failures: runaway software and bus cycles that never finish. A one-shot protection control register is set up by boot code: the first write after reset takes effect and locks the register until the next reset. The software watchdog counts enabled clock ticks and requests a reset when its period runs out. Software keeps it quiet by writing the two-byte key 0x55 then 0xAA to a service register.

The bus monitor starts a timer on each bus-cycle start and stops it on the acknowledge. When the timer runs out before the acknowledge, the monitor pulses a bus-fault output. Each timeout also sets a sticky cause bit in a status register that software can read. Both timers advance only on cycles where the clock enable is high.

Register port, byte wide. Address 0 is the control register. Address 1 is the service register, which reads as 0. Address 2 is the status register. Read data is registered: the register selected by the address at one rising edge is on the read-data output after that edge.

Top module: `sysprot_unit`

## Requirements
- R1: After reset, both request outputs are low, and addresses 0, 1 and 2 read 0x00 with the default control reset value of 0x00.
- R2: Only the first write to address 0 after reset is stored, and every later write leaves the readback unchanged. Control fields: bit 7 is watchdog enable, bit 6 is watchdog prescale, bits 5:4 are watchdog period select, bit 2 is bus monitor enable and bits 1:0 are bus timeout select.
- R3: A write of 0x55 to address 1, followed by a write of 0xAA to address 1, restarts the watchdog count from zero at the 0xAA edge. Repeated 0x55 writes keep the key armed.
- R4: Any address-1 write other than 0x55 disarms the key. A 0xAA write with no 0x55 just before it does not service the watchdog.
- R5: While control bit 7 is 0, the watchdog reset request never asserts.
- R6: With bit 7 set, the reset request is a single-cycle pulse. It goes high after the P-th enabled tick since the last restart, where P = 2^(WD_BASE_SHIFT + WD_STEP_SHIFT*sel), multiplied by 2^WD_PRE_SHIFT when bit 6 is set. The count restarts after each timeout.
- R7: Cycles with the clock enable low do not advance either timer.
- R8: A watchdog timeout sets status bit 0 and a bus timeout sets status bit 1. Both bits stay set until reset.
- R9: With bit 2 set, a bus-cycle start that sees no acknowledge for 2^(BM_MAX_SHIFT - sel) enabled ticks gives a single-cycle bus-fault pulse. With bit 2 clear, no fault is raised.
- R10: An acknowledge that arrives on or before the terminal tick edge cancels the fault.
- R11: A key completion that falls on the same edge as the watchdog's terminal tick wins: no reset request is raised, and a full new period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Tick enable for both timers |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| bus_start | input | 1 | Bus cycle start |
| bus_ack | input | 1 | Bus cycle acknowledge |
| wdog_rst_req | output | 1 | Watchdog reset request pulse |
| bus_fault | output | 1 | Bus timeout pulse |

## Verification
The two events that can land on one edge are a completed key sequence and the watchdog's terminal tick; the bus acknowledge and the bus monitor's terminal tick form the same kind of pair. The bench counts edges from the last restart so that the 0x55 and 0xAA writes land exactly on the terminal tick. It then checks that no reset request appears and that the next timeout comes one full period after the 0xAA edge. The bus case places the acknowledge on the edge of the last tick and checks that no fault follows.

// File: rtl/sysprot_pkg.sv
package sysprot_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SVC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  localparam logic [DATA_W-1:0] KEY_ARM  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_FIRE = 8'hAA;

  typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_e;

  // control byte layout, MSB first
  typedef struct packed {
    logic       wd_en;
    logic       wd_pre;
    logic [1:0] wd_sel;
    logic       spare;
    logic       bm_en;
    logic [1:0] bm_sel;
  } prot_ctrl_t;
endpackage

// File: rtl/sysprot_ctrl_reg.sv
module sysprot_ctrl_reg
  import sysprot_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output prot_ctrl_t        ctrl,
  output logic              locked
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= prot_ctrl_t'(RESET_VAL);
      locked <= 1'b0;
    end else if (wr_en && !locked) begin
      ctrl   <= prot_ctrl_t'(wdata);
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/sysprot_key_seq.sv
module sysprot_key_seq
  import sysprot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              fire
);
  key_state_e state_q;

  // completion is flagged in the same cycle as the closing write
  always_comb begin
    fire = wr_en && (wdata == KEY_FIRE) && (state_q == KEY_ARMED);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KEY_IDLE;
    end else if (wr_en) begin
      state_q <= (wdata == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
    end
  end
endmodule

// File: rtl/sysprot_wdog_timer.sv
module sysprot_wdog_timer #(
  parameter int BASE_SHIFT = 9,
  parameter int STEP_SHIFT = 2,
  parameter int PRE_SHIFT  = 9,
  parameter int CNT_W      = BASE_SHIFT + 3*STEP_SHIFT + PRE_SHIFT
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       enable,
  input  logic       pre,
  input  logic [1:0] sel,
  input  logic       service,
  output logic       expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   limit;
  logic             terminal;
  int               shamt;

  always_comb begin
    shamt    = BASE_SHIFT + STEP_SHIFT*int'(sel) + (pre ? PRE_SHIFT : 0);
    limit    = {{CNT_W{1'b0}}, 1'b1} << shamt;
    terminal = ({1'b0, cnt_q} == (limit - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (!enable) begin
        cnt_q <= '0;
      end else if (service) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (terminal) begin
          cnt_q  <= '0;
          expire <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sysprot_bus_mon.sv
module sysprot_bus_mon #(
  parameter int MAX_SHIFT = 6,
  parameter int CNT_W     = MAX_SHIFT
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       enable,
  input  logic [1:0] sel,
  input  logic       cyc_start,
  input  logic       cyc_ack,
  output logic       timeout
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   limit;
  logic             terminal;

  always_comb begin
    limit    = {{CNT_W{1'b0}}, 1'b1} << (MAX_SHIFT - int'(sel));
    terminal = ({1'b0, cnt_q} == (limit - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (!enable) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (cyc_start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (cyc_ack) begin
        busy_q <= 1'b0;
      end else if (busy_q && tick) begin
        if (terminal) begin
          busy_q  <= 1'b0;
          timeout <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sysprot_unit.sv
module sysprot_unit
  import sysprot_pkg::*;
#(
  parameter logic [DATA_W-1:0] CTRL_RESET    = 8'h00,
  parameter int                WD_BASE_SHIFT = 9,
  parameter int                WD_STEP_SHIFT = 2,
  parameter int                WD_PRE_SHIFT  = 9,
  parameter int                BM_MAX_SHIFT  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              bus_start,
  input  logic              bus_ack,
  output logic              wdog_rst_req,
  output logic              bus_fault
);
  localparam int WD_CNT_W = WD_BASE_SHIFT + 3*WD_STEP_SHIFT + WD_PRE_SHIFT;
  localparam int BM_CNT_W = BM_MAX_SHIFT;

  prot_ctrl_t ctrl_q;
  logic       locked;
  logic       svc_fire;
  logic       wd_cause;
  logic       bus_cause;
  logic       wr_ctrl;
  logic       wr_svc;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_svc  = reg_wr && (reg_addr == ADDR_SVC);

  sysprot_ctrl_reg #(.RESET_VAL(CTRL_RESET)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_ctrl), .wdata(reg_wdata),
    .ctrl(ctrl_q), .locked(locked)
  );

  sysprot_key_seq u_key (
    .clk(clk), .rst(rst), .wr_en(wr_svc), .wdata(reg_wdata), .fire(svc_fire)
  );

  sysprot_wdog_timer #(
    .BASE_SHIFT(WD_BASE_SHIFT), .STEP_SHIFT(WD_STEP_SHIFT),
    .PRE_SHIFT(WD_PRE_SHIFT), .CNT_W(WD_CNT_W)
  ) u_wdog (
    .clk(clk), .rst(rst), .tick(clk_en), .enable(ctrl_q.wd_en),
    .pre(ctrl_q.wd_pre), .sel(ctrl_q.wd_sel), .service(svc_fire),
    .expire(wdog_rst_req)
  );

  sysprot_bus_mon #(.MAX_SHIFT(BM_MAX_SHIFT), .CNT_W(BM_CNT_W)) u_bmon (
    .clk(clk), .rst(rst), .tick(clk_en), .enable(ctrl_q.bm_en),
    .sel(ctrl_q.bm_sel), .cyc_start(bus_start), .cyc_ack(bus_ack),
    .timeout(bus_fault)
  );

  // sticky cause flags, cleared only by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      wd_cause  <= 1'b0;
      bus_cause <= 1'b0;
    end else begin
      if (wdog_rst_req) wd_cause  <= 1'b1;
      if (bus_fault)    bus_cause <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADDR_CTRL: reg_rdata <= ctrl_q;
        ADDR_STAT: reg_rdata <= {{(DATA_W-2){1'b0}}, bus_cause, wd_cause};
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sysprot_unit_chk.sv
module sysprot_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       clk_en,
  input logic [7:0] ctrl_q,
  input logic       locked,
  input logic       svc_fire,
  input logic       bus_ack,
  input logic       wdog_rst_req,
  input logic       bus_fault,
  input logic       wd_cause,
  input logic       bus_cause
);
  assert_ctrl_locked_R2: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(ctrl_q));

  assert_wd_off_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[7] && !$past(ctrl_q[7])) |-> !wdog_rst_req);

  assert_wd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_req |=> !wdog_rst_req);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> (!wdog_rst_req && !bus_fault));

  assert_wd_cause_R8: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_req |=> wd_cause);

  assert_bus_cause_R8: assert property (@(posedge clk) disable iff (rst)
    bus_fault |=> bus_cause);

  assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !$fell(wd_cause) && !$fell(bus_cause));

  assert_bus_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    bus_fault |=> !bus_fault);

  assert_bus_off_R9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[2] && !$past(ctrl_q[2])) |-> !bus_fault);

  assert_ack_wins_R10: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_fault);

  assert_service_wins_R11: assert property (@(posedge clk) disable iff (rst)
    svc_fire |=> !wdog_rst_req);
endmodule

bind sysprot_unit sysprot_unit_chk u_chk (
  .clk(clk), .rst(rst), .clk_en(clk_en), .ctrl_q(ctrl_q), .locked(locked),
  .svc_fire(svc_fire), .bus_ack(bus_ack), .wdog_rst_req(wdog_rst_req),
  .bus_fault(bus_fault), .wd_cause(wd_cause), .bus_cause(bus_cause)
);

// File: tb/sysprot_unit_bench.sv
module sysprot_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 2;
  localparam int WS = 2;
  localparam int WP = 3;
  localparam int BM = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       bus_start = 1'b0;
  logic       bus_ack = 1'b0;
  logic       wdog_rst_req;
  logic       bus_fault;

  int checks = 0;
  int fails = 0;
  int edge_n = 0;
  bit done = 1'b0;

  sysprot_unit #(
    .CTRL_RESET(8'h00), .WD_BASE_SHIFT(WB), .WD_STEP_SHIFT(WS),
    .WD_PRE_SHIFT(WP), .BM_MAX_SHIFT(BM)
  ) u_sysprot_unit (
    .clk(clk), .rst(rst), .clk_en(clk_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_start(bus_start), .bus_ack(bus_ack),
    .wdog_rst_req(wdog_rst_req), .bus_fault(bus_fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    step();
    d = reg_rdata;
  endtask

  task automatic wait_rst(input int maxn, output int at);
    at = -1;
    for (int i = 0; i < maxn; i++) begin
      step();
      if (wdog_rst_req) begin at = edge_n; break; end
    end
  endtask

  task automatic wait_fault(input int maxn, output int at);
    at = -1;
    for (int i = 0; i < maxn; i++) begin
      step();
      if (bus_fault) begin at = edge_n; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", edge_n, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int w, s, at, at2, p, l;
    bit seen;

    // R1 reset state, then R2 and R5 with the watchdog left off
    do_reset();
    chk(!wdog_rst_req && !bus_fault, "R1 outputs", int'(wdog_rst_req), 0);
    rd(2'd0, d); chk(d == 8'h00, "R1 ctrl", d, 0);
    rd(2'd1, d); chk(d == 8'h00, "R1 svc", d, 0);
    rd(2'd2, d); chk(d == 8'h00, "R1 stat", d, 0);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'hB7);
    rd(2'd0, d); chk(d == 8'h00, "R2 second write ignored", d, 0);
    bus_start = 1'b1; step(); bus_start = 1'b0;
    wait_fault(40, at); chk(at == -1, "R9 monitor off", at, -1);
    wait_rst(600, at); chk(at == -1, "R5 watchdog off", at, -1);
    rd(2'd2, d); chk(d == 8'h00, "R8 no cause", d, 0);

    // sweep over every period select and prescale setting
    for (int c = 0; c < 4; c++) begin
      for (int pr = 0; pr < 2; pr++) begin
        logic [7:0] cv;
        cv = {1'b1, pr[0], c[1:0], 1'b0, 1'b1, c[1:0]};
        p = 1 << (WB + WS*c + WP*pr);
        l = 1 << (BM - c);
        do_reset();
        wr(2'd0, cv); w = edge_n;
        rd(2'd0, d); chk(d == cv, "R2 first write stored", d, cv);
        wait_rst(p + 10, at); chk(at - w == p, "R6 period", at - w, p);
        step(); chk(!wdog_rst_req, "R6 single pulse", int'(wdog_rst_req), 0);
        rd(2'd2, d); chk(d[0] == 1'b1, "R8 watchdog cause", d, 1);
        bus_start = 1'b1; step(); s = edge_n; bus_start = 1'b0;
        wait_fault(l + 5, at); chk(at - s == l, "R9 bus timeout", at - s, l);
        step(); chk(!bus_fault, "R9 single pulse", int'(bus_fault), 0);
        rd(2'd2, d); chk(d[1:0] == 2'b11, "R8 both causes", d, 3);
        bus_start = 1'b1; step(); bus_start = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < l - 1; k++) begin step(); if (bus_fault) seen = 1'b1; end
        bus_ack = 1'b1; step(); bus_ack = 1'b0;
        if (bus_fault) seen = 1'b1;
        for (int k = 0; k < l + 2; k++) begin step(); if (bus_fault) seen = 1'b1; end
        chk(!seen, "R10 ack on terminal edge", int'(seen), 0);
      end
    end

    // key sequence checks, period 16
    p = 1 << (WB + WS);
    do_reset();
    wr(2'd0, 8'h90);
    repeat (3) step();
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA); s = edge_n;
    wait_rst(p + 10, at); chk(at - s == p, "R3 service restarts", at - s, p);
    wr(2'd1, 8'h55); wr(2'd1, 8'h12); wr(2'd1, 8'hAA);
    wait_rst(p + 10, at2); chk(at2 - at == p, "R4 broken key", at2 - at, p);
    wr(2'd1, 8'hAA);
    wait_rst(p + 10, at); chk(at - at2 == p, "R4 lone close byte", at - at2, p);
    while (edge_n < at + p - 2) step();
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA); s = edge_n;
    chk(s == at + p, "R11 collision placed", s, at + p);
    chk(!wdog_rst_req, "R11 service wins", int'(wdog_rst_req), 0);
    wait_rst(p + 10, at2); chk(at2 - s == p, "R11 full new period", at2 - s, p);
    repeat (3) step();
    clk_en = 1'b0; repeat (20) step(); clk_en = 1'b1;
    wait_rst(p + 10, at); chk(at - at2 == p + 20, "R7 frozen ticks", at - at2, p + 20);
    wr(2'd1, 8'h55); wr(2'd1, 8'h55); wr(2'd1, 8'hAA); s = edge_n;
    wait_rst(p + 10, at2); chk(at2 - s == p, "R3 repeated arm byte", at2 - s, p);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk(d == 8'h90, "R2 locked", d, 8'h90);
    rd(2'd1, d); chk(d == 8'h00, "R3 service reads zero", d, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule